// File: doc/BRIEF.md
# Serial FPGA Configuration Master

This block configures a target FPGA over a bit-serial slave configuration link. A start pulse, together with a byte count, begins a load. The block first resets the target's configuration logic and goes through a two-step handshake on the open-drain init line. It then takes bitstream bytes from a byte-wide valid/ready stream and shifts each one out on the data pin with a paced configuration clock.

During the load it watches the init and done lines. If init goes active while done is still low, the target has reported a checksum failure, and the load stops. After the last byte it keeps clocking with the data pin high until done rises. Every wait on the target has a cycle-count timeout. The result of a load is shown as one of three sticky outcome flags: success, timeout or CRC error. Both status inputs pass through a two-flop synchronizer before the control logic uses them.

Top module: `serial_cfg_loader`

## Requirements
- R1: Out of reset and whenever the block is not busy, it drives `tgt_prog_n_o` high, `tgt_cclk_o` low, `tgt_din_o` low and `s_ready_o` low.
- R2: On `start_i` the block drives `tgt_prog_n_o` low, with `tgt_cclk_o` low, until the synchronized `tgt_init_n_i` reads low. If `TIMEOUT_CYC` cycles pass first, the load ends with `timeout_o`, and `busy_o` falls between `TIMEOUT_CYC` and `TIMEOUT_CYC`+4 cycles after the start.
- R3: Once init reads low, `tgt_prog_n_o` returns high and the block waits for init to read high again. The same `TIMEOUT_CYC` limit applies, and a timeout ends the load with `timeout_o`.
- R4: Each byte is sent most significant bit first. `tgt_din_o` changes only while `tgt_cclk_o` is low, and each high phase of the clock lasts exactly `HALF_DIV` system cycles.
- R5: Before each byte, if init reads low while done reads low, the load ends with `crc_err_o` and no further stream byte is accepted.
- R6: After the counted bytes have been sent, `tgt_din_o` is held high and `tgt_cclk_o` keeps toggling until done reads high. The load then ends with `ok_o`. A byte count of zero goes straight to this phase.
- R7: If done does not read high within `TIMEOUT_CYC` cycles after the data ends, the load ends with `timeout_o`.
- R8: `s_ready_o` is high only while the shifter is empty, with the clock low and no bit of a byte still pending. Exactly `byte_count_i` bytes are accepted in a successful load.
- R9: A `start_i` pulse while `busy_o` is high has no effect on the bit stream or on the number of bytes accepted.
- R10: At most one outcome flag is high at any time. No flag is high while `busy_o` is high. A flag stays set until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins a load |
| byte_count_i | input | CNT_W | Number of bitstream bytes, sampled on start |
| s_data_i | input | 8 | Stream byte |
| s_valid_i | input | 1 | Stream byte is valid |
| s_ready_o | output | 1 | Block accepts a stream byte |
| tgt_prog_n_o | output | 1 | Target configuration reset, active low |
| tgt_cclk_o | output | 1 | Configuration clock to the target |
| tgt_din_o | output | 1 | Serial configuration data |
| tgt_init_n_i | input | 1 | Target init status, active low, asynchronous |
| tgt_done_i | input | 1 | Target done status, asynchronous |
| busy_o | output | 1 | A load is in progress |
| ok_o | output | 1 | Last load finished with done high |
| timeout_o | output | 1 | Last load stopped on a timeout |
| crc_err_o | output | 1 | Last load stopped on a checksum error |

## Verification
A wrong shift register or bit counter shows up on the data pin at the very next rising clock edge, as a bit that differs from the one the scoreboard expects. A miscounted byte counter shows up as an extra or missing ready handshake, or as a tail phase that starts at the wrong time. A state machine that ignores a status line or an expired timer either hangs with busy high, which the watchdog catches, or reports the wrong outcome flag when busy falls. The bench checks this flag one cycle later, together with the elapsed time for the first-phase timeout.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned BIT_W  = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG_LOW,
        ST_PROG_REL,
        ST_FETCH,
        ST_SHIFT_LO,
        ST_SHIFT_HI,
        ST_TAIL_LO,
        ST_TAIL_HI
    } ld_state_e;
endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
    parameter int unsigned W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/scl_pacer.sv
module scl_pacer #(
    parameter int unsigned HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);
    localparam int unsigned PW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(HALF_DIV - 1);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr_i || cnt_q == LAST) cnt_d = '0;
        else                        cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = !clr_i && (cnt_q == LAST);
endmodule

// File: rtl/scl_timer.sv
module scl_timer #(
    parameter int unsigned TIMEOUT_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic expired_o
);
    localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT_CYC);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr_i)               cnt_d = '0;
        else if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
        else                     cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == LIMIT);
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
    import serial_cfg_pkg::*;
#(
    parameter int unsigned HALF_DIV    = 4,
    parameter int unsigned TIMEOUT_CYC = 1_000_000,
    parameter int unsigned CNT_W       = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] byte_count_i,
    input  logic [7:0]       s_data_i,
    input  logic             s_valid_i,
    output logic             s_ready_o,
    output logic             tgt_prog_n_o,
    output logic             tgt_cclk_o,
    output logic             tgt_din_o,
    input  logic             tgt_init_n_i,
    input  logic             tgt_done_i,
    output logic             busy_o,
    output logic             ok_o,
    output logic             timeout_o,
    output logic             crc_err_o
);
    typedef struct packed {
        ld_state_e          state;
        logic [CNT_W-1:0]   rem;
        logic [BYTE_W-1:0]  sh;
        logic [BIT_W-1:0]   bitcnt;
        logic               prog_n;
        logic               cclk;
        logic               din;
        logic               ok;
        logic               to;
        logic               crc;
    } ld_regs_t;

    localparam ld_regs_t RESET_REGS = '{
        state: ST_IDLE, rem: '0, sh: '0, bitcnt: '0,
        prog_n: 1'b1, cclk: 1'b0, din: 1'b0,
        ok: 1'b0, to: 1'b0, crc: 1'b0
    };
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    ld_regs_t regs_d, regs_q;
    logic     init_n_s, done_s;
    logic     tick, expired;
    logic     tmr_clr, pace_clr, ready;

    // two-flop synchronizers; init idles high, done idles low
    scl_sync #(.W(2), .RST_VAL(2'b01)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({tgt_done_i, tgt_init_n_i}),
        .sync_o  ({done_s, init_n_s})
    );

    scl_pacer #(.HALF_DIV(HALF_DIV)) pacer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (pace_clr),
        .tick_o (tick)
    );

    scl_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (tmr_clr),
        .expired_o (expired)
    );

    always_comb begin
        regs_d   = regs_q;
        tmr_clr  = 1'b0;
        pace_clr = 1'b1;
        ready    = 1'b0;

        unique case (regs_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    regs_d.state = ST_PROG_LOW;
                    regs_d.rem   = byte_count_i;
                    regs_d.ok    = 1'b0;
                    regs_d.to    = 1'b0;
                    regs_d.crc   = 1'b0;
                    tmr_clr      = 1'b1;
                end
            end
            ST_PROG_LOW: begin
                if (!init_n_s) begin
                    regs_d.state = ST_PROG_REL;
                    tmr_clr      = 1'b1;
                end else if (expired) begin
                    regs_d.state = ST_IDLE;
                    regs_d.to    = 1'b1;
                end
            end
            ST_PROG_REL: begin
                if (init_n_s) begin
                    regs_d.state = ST_FETCH;
                end else if (expired) begin
                    regs_d.state = ST_IDLE;
                    regs_d.to    = 1'b1;
                end
            end
            ST_FETCH: begin
                if (!init_n_s && !done_s) begin
                    regs_d.state = ST_IDLE;
                    regs_d.crc   = 1'b1;
                end else if (regs_q.rem == '0) begin
                    regs_d.state = ST_TAIL_LO;
                    tmr_clr      = 1'b1;
                end else begin
                    ready = 1'b1;
                    if (s_valid_i) begin
                        regs_d.sh     = s_data_i;
                        regs_d.bitcnt = '0;
                        regs_d.rem    = regs_q.rem - 1'b1;
                        regs_d.state  = ST_SHIFT_LO;
                    end
                end
            end
            ST_SHIFT_LO: begin
                pace_clr = 1'b0;
                if (tick) regs_d.state = ST_SHIFT_HI;
            end
            ST_SHIFT_HI: begin
                pace_clr = 1'b0;
                if (tick) begin
                    regs_d.sh     = {regs_q.sh[BYTE_W-2:0], 1'b0};
                    regs_d.bitcnt = regs_q.bitcnt + 1'b1;
                    regs_d.state  = (regs_q.bitcnt == LAST_BIT) ? ST_FETCH : ST_SHIFT_LO;
                end
            end
            ST_TAIL_LO, ST_TAIL_HI: begin
                pace_clr = 1'b0;
                if (done_s) begin
                    regs_d.state = ST_IDLE;
                    regs_d.ok    = 1'b1;
                end else if (expired) begin
                    regs_d.state = ST_IDLE;
                    regs_d.to    = 1'b1;
                end else if (tick) begin
                    regs_d.state = (regs_q.state == ST_TAIL_LO) ? ST_TAIL_HI : ST_TAIL_LO;
                end
            end
            default: regs_d = RESET_REGS;
        endcase

        // pin levels follow the next state so they are registered
        regs_d.prog_n = (regs_d.state != ST_PROG_LOW);
        regs_d.cclk   = (regs_d.state == ST_SHIFT_HI) || (regs_d.state == ST_TAIL_HI);
        unique case (regs_d.state)
            ST_SHIFT_LO, ST_SHIFT_HI: regs_d.din = regs_d.sh[BYTE_W-1];
            ST_TAIL_LO, ST_TAIL_HI:   regs_d.din = 1'b1;
            default:                  regs_d.din = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= RESET_REGS;
        else        regs_q <= regs_d;
    end

    assign s_ready_o    = ready;
    assign tgt_prog_n_o = regs_q.prog_n;
    assign tgt_cclk_o   = regs_q.cclk;
    assign tgt_din_o    = regs_q.din;
    assign busy_o       = (regs_q.state != ST_IDLE);
    assign ok_o         = regs_q.ok;
    assign timeout_o    = regs_q.to;
    assign crc_err_o    = regs_q.crc;

    // R1: idle pin levels
    a_r1_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (tgt_prog_n_o && !tgt_cclk_o && !s_ready_o));

    // R2: no configuration clock while the target is held in reset
    a_r2_no_clock_in_prog: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_prog_n_o |-> !tgt_cclk_o);

    // R4: data is settled before the rising clock edge
    a_r4_din_settled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_cclk_o) |-> $stable(tgt_din_o));

    // R8: one accepted byte closes the ready window
    a_r8_single_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid_i && s_ready_o) |=> !s_ready_o);

    // R10: outcome flags are exclusive and absent during a load
    a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ok_o, timeout_o, crc_err_o}));
    a_r10_no_flag_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !(ok_o || timeout_o || crc_err_o));
endmodule

// File: tb/serial_cfg_loader_tb_top.sv
module serial_cfg_loader_tb_top;
    localparam int unsigned HALF_DIV = 3;
    localparam int unsigned TO_CYC   = 400;
    localparam int unsigned CNT_W    = 16;
    localparam int M_NORMAL  = 0;
    localparam int M_NO_INIT = 1;
    localparam int M_STUCK   = 2;
    localparam int M_NO_DONE = 3;
    localparam int M_CRC     = 4;
    localparam int CRC_AT    = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0;
    logic [CNT_W-1:0] byte_count = '0;
    logic [7:0] s_data = '0;
    logic s_valid = 1'b0, s_ready;
    logic prog_n, cclk, din, busy, ok, to, crc;
    logic init_n = 1'b1, done = 1'b0;

    int compared = 0, mismatched = 0;
    bit exp_q[$];
    logic [7:0] mem [16];
    int mode = M_NORMAL;
    int bits_rx = 0, total_bits = 0, tail_clks = 0, tail_din_bad = 0;
    int dly = 0, seen_prog = 0, accepted = 0, elapsed = 0;
    int r4_viol = 0, r8_viol = 0, r2_viol = 0, hi_len = 0, data_rise = 0;
    logic cclk_prev = 1'b0, din_prev = 1'b0;

    always #5 clk = ~clk;

    serial_cfg_loader #(.HALF_DIV(HALF_DIV), .TIMEOUT_CYC(TO_CYC), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .byte_count_i(byte_count),
        .s_data_i(s_data), .s_valid_i(s_valid), .s_ready_o(s_ready),
        .tgt_prog_n_o(prog_n), .tgt_cclk_o(cclk), .tgt_din_o(din),
        .tgt_init_n_i(init_n), .tgt_done_i(done), .busy_o(busy),
        .ok_o(ok), .timeout_o(to), .crc_err_o(crc)
    );

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        compared++;
        if (!cond) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // target model and scoreboard monitor, sampled away from the clock edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (!prog_n) begin
                seen_prog = 1;
                if (mode != M_NO_INIT) begin
                    if (dly == 4) init_n = 1'b0; else dly++;
                end
            end else if (seen_prog == 1 && mode != M_STUCK) begin
                init_n = 1'b1;
                seen_prog = 0;
            end
            if (s_ready && (cclk || (bits_rx % 8) != 0)) r8_viol++;
            if (cclk && cclk_prev && din != din_prev) r4_viol++;
            if (cclk) hi_len++;
            if (!cclk && cclk_prev) begin
                if (data_rise == 1 && hi_len != HALF_DIV) r4_viol++;
                hi_len = 0;
            end
            if (cclk && !cclk_prev) begin
                hi_len = 1;
                if (bits_rx < total_bits) begin
                    data_rise = 1;
                    compared++;
                    if (exp_q.size() == 0) begin
                        mismatched++;
                        $display("FAIL R4 actual=%0d expected=none (bit %0d)", din, bits_rx);
                    end else begin
                        bit e;
                        e = exp_q.pop_front();
                        if (din !== e) begin
                            mismatched++;
                            $display("FAIL R4 actual=%0d expected=%0d (bit %0d)", din, e, bits_rx);
                        end
                    end
                    bits_rx++;
                    if (mode == M_CRC && bits_rx == CRC_AT * 8) init_n = 1'b0;
                end else begin
                    data_rise = 0;
                    tail_clks++;
                    if (!din) tail_din_bad++;
                    if (tail_clks == 3 && mode != M_NO_DONE) done = 1'b1;
                end
            end
            cclk_prev = cclk;
            din_prev  = din;
        end
    end

    task automatic run_load(input int n, input int m, input bit poke);
        int i;
        mode = m; init_n = 1'b1; done = 1'b0; dly = 0; seen_prog = 0;
        bits_rx = 0; tail_clks = 0; tail_din_bad = 0; accepted = 0;
        total_bits = n * 8; r2_viol = 0; exp_q.delete();
        @(negedge clk); start = 1'b1; byte_count = CNT_W'(n);
        @(negedge clk); start = 1'b0;
        chk(busy && !ok && !to && !crc, "R10 flags cleared on start", {ok, to, crc}, 0);
        i = 0; elapsed = 0;
        while (busy && elapsed < 20000) begin
            @(negedge clk); elapsed++;
            start = poke && (elapsed == 30);
            if (mode == M_NO_INIT && busy && prog_n !== 1'b0) r2_viol++;
            if (i < n) begin s_valid = 1'b1; s_data = mem[i]; end
            else s_valid = 1'b0;
            if (s_valid && s_ready) begin
                for (int b = 7; b >= 0; b--) exp_q.push_back(mem[i][b]);
                i++; accepted++;
                @(posedge clk); #1;
                if (i < n) s_data = mem[i]; else s_valid = 1'b0;
            end
        end
        s_valid = 1'b0; start = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk_idle(input string req);
        chk(prog_n && !cclk && !din && !s_ready && !busy, req,
            {prog_n, cclk, din, s_ready, busy}, 5'b10000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        mem[0] = 8'hA5; mem[1] = 8'h3C; mem[2] = 8'h81; mem[3] = 8'h7E;
        mem[4] = 8'h01; mem[5] = 8'hFF;
        for (int k = 6; k < 16; k++) mem[k] = 8'(k * 37);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk_idle("R1 reset levels");
        chk(!ok && !to && !crc, "R1 reset flags", {ok, to, crc}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R4 R6 R8: normal load
        run_load(4, M_NORMAL, 1'b0);
        chk(ok && !to && !crc, "R6 success flag", {ok, to, crc}, 3'b100);
        chk(accepted == 4, "R8 bytes accepted", accepted, 4);
        chk(exp_q.size() == 0 && bits_rx == 32, "R4 all bits sent", bits_rx, 32);
        chk(tail_din_bad == 0 && tail_clks >= 3, "R6 tail din high", tail_din_bad, 0);
        chk(r4_viol == 0, "R4 din stable and high phase length", r4_viol, 0);
        chk(r8_viol == 0, "R8 ready only when empty", r8_viol, 0);
        chk_idle("R1 idle after success");
        repeat (10) @(negedge clk);
        chk(ok && !busy, "R10 flag held", ok, 1);

        // R9: start pulse mid-load is ignored
        run_load(6, M_NORMAL, 1'b1);
        chk(ok, "R9 load completes", ok, 1);
        chk(accepted == 6 && bits_rx == 48 && exp_q.size() == 0, "R9 stream unchanged", accepted, 6);

        // R6: zero byte count goes directly to tail
        run_load(0, M_NORMAL, 1'b0);
        chk(ok && accepted == 0 && bits_rx == 0, "R6 zero count", accepted, 0);
        chk(tail_clks >= 3 && tail_din_bad == 0, "R6 zero count tail", tail_clks, 3);

        // R2: init never goes low
        run_load(2, M_NO_INIT, 1'b0);
        chk(to && !ok && !crc, "R2 timeout flag", {ok, to, crc}, 3'b010);
        chk(elapsed >= TO_CYC && elapsed <= TO_CYC + 4, "R2 timeout duration", elapsed, TO_CYC);
        chk(r2_viol == 0, "R2 prog held low while waiting", r2_viol, 0);
        chk(accepted == 0, "R2 no byte accepted", accepted, 0);
        chk_idle("R1 idle after timeout");

        // R3: init never released
        run_load(2, M_STUCK, 1'b0);
        chk(to && !ok && !crc, "R3 timeout flag", {ok, to, crc}, 3'b010);
        chk(accepted == 0 && elapsed >= TO_CYC, "R3 waited full window", elapsed, TO_CYC);
        chk_idle("R1 idle after init timeout");

        // R7: done never rises
        run_load(3, M_NO_DONE, 1'b0);
        chk(to && !ok && !crc, "R7 tail timeout flag", {ok, to, crc}, 3'b010);
        chk(accepted == 3 && bits_rx == 24, "R7 data sent before tail", bits_rx, 24);
        chk(tail_clks > 3, "R7 clock kept toggling", tail_clks, 4);

        // R5: checksum error after byte CRC_AT
        run_load(5, M_CRC, 1'b0);
        chk(crc && !ok && !to, "R5 crc flag", {ok, to, crc}, 3'b001);
        chk(accepted == CRC_AT, "R5 no further bytes", accepted, CRC_AT);
        chk(exp_q.size() == 0 && bits_rx == CRC_AT * 8, "R5 bits sent", bits_rx, CRC_AT * 8);
        chk_idle("R1 idle after crc");
        chk(r8_viol == 0 && r4_viol == 0, "R8 R4 overall", r8_viol + r4_viol, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule